// File: doc/BRIEF.md
# Beacon Clock Offset Estimator

This block sits in a mesh node's time-division MAC and listens during the synchronization sub-frame. The sub-frame is a fixed run of slots. The gateway sends a time-stamped beacon in the first slot. Every node that hears a beacon relays it once, unchanged, in a later slot of its own. When the block accepts a beacon, it estimates when the gateway sent it. To do this it removes the one-hop link delay and the slots that passed since slot 1 from the local receive time. The difference between the gateway stamp and that estimate is the node's clock offset.

The block uses only the first valid beacon of each sub-frame and holds the beacon's stamp for re-broadcast. The computed offset stays pending until the scheduler signals the end of the last sub-frame slot. At that strobe every node commits its offset at the same moment, and the block reports the corrected local time. Slot scheduling and radio framing are handled elsewhere.

Top module: `beacon_offset_est`

## Requirements
- R1: The pending offset is `ts - ((rx - dly) - (i-1)*dur)`. Here `ts` is the beacon stamp, `rx` is the local receive time, `dly` is the link delay estimate, `dur` is the slot duration and `i` is the 1-based sub-frame slot of reception.
- R2: Only the first accepted beacon of a sub-frame is used. Later beacons in the same sub-frame change neither the held stamp nor the pending offset.
- R3: One cycle after a beacon is accepted, `bcn_held_o` is 1 and `held_ts_o` equals the received stamp, unmodified.
- R4: `offset_o` changes only in the cycle after `scs_end_i`. A pending offset is not visible before then.
- R5: One cycle after `scs_end_i`, `apply_o` pulses high for one cycle. If a beacon is held, `offset_o` takes the pending offset and `corr_time_o` equals `local_time_i` (as sampled with the strobe) plus that offset.
- R6: If no beacon is held at `scs_end_i`, `corr_time_o` equals the sampled `local_time_i` and `offset_o` keeps its value.
- R7: `scs_start_i` clears `bcn_held_o` one cycle later. A beacon arriving in the same cycle as `scs_start_i` is accepted as the first beacon of the new sub-frame.
- R8: A beacon whose slot index is 0 or greater than `SCS_SLOTS` is discarded.
- R9: A beacon arriving in the same cycle as `scs_end_i` is discarded.
- R10: All time arithmetic wraps modulo 2^32. `offset_o` is read as a signed 32-bit value.
- R11: After reset, `bcn_held_o`, `held_ts_o`, `offset_o`, `apply_o` and `corr_time_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scs_start_i | input | 1 | Strobe: a sync sub-frame begins |
| scs_end_i | input | 1 | Strobe: last sub-frame slot has ended |
| bcn_valid_i | input | 1 | A beacon was received this cycle |
| bcn_ts_i | input | 32 | Gateway time stamp carried in the beacon |
| bcn_slot_i | input | SLOT_W (5) | 1-based sub-frame slot of reception |
| rx_time_i | input | 32 | Local time at reception |
| link_delay_i | input | 32 | Configured one-hop delay estimate |
| slot_dur_i | input | 32 | Sub-frame slot duration |
| local_time_i | input | 32 | Current local clock value |
| bcn_held_o | output | 1 | A beacon is held for this sub-frame |
| held_ts_o | output | 32 | Held beacon stamp for re-broadcast |
| offset_o | output | 32 | Committed signed clock offset |
| apply_o | output | 1 | One-cycle pulse: corrected time valid |
| corr_time_o | output | 32 | Corrected local time |

## Verification
The offset estimate is tried with beacons in slot 1, where the slot term is zero and only the link delay matters. It is also tried in middle slots and in the last legal slot, which separates a correct `(i-1)` factor from an off-by-one. Pairs of beacons inside one sub-frame, with different stamps, show whether the first or the last one wins. Stamps and receive times placed around the 2^32 wrap expose sign and width mistakes. Sub-frames with no beacon, beacons at out-of-range slots, and beacons that coincide with the start or end strobes test the edge rules.

// File: rtl/beacon_pkg.sv
// Shared widths and types for the beacon offset estimator.
// Assumes time stamps are unsigned microsecond counts that wrap.
package beacon_pkg;
    localparam int TS_W = 32;
    typedef logic [TS_W-1:0]        ts_t;
    typedef logic signed [TS_W-1:0] off_t;
endpackage

// File: rtl/bo_offset_calc.sv
// Combinational offset estimate for one received beacon.
// Traces the receive time back to the gateway send time, first removing
// the hop delay and then (slot-1) slot durations, and subtracts that from
// the carried stamp. Assumes the slot index is 1-based; slot legality is
// checked by the caller. All arithmetic wraps modulo 2^TS_W.
module bo_offset_calc
    import beacon_pkg::*;
#(
    parameter int SLOT_W = 5
) (
    input  ts_t              bcn_ts,
    input  logic [SLOT_W-1:0] slot_idx,
    input  ts_t              rx_time,
    input  ts_t              link_delay,
    input  ts_t              slot_dur,
    output off_t             offset
);
    ts_t slots_back;
    ts_t relay_tx;
    ts_t gw_tx;
    ts_t slot_span;

    // Estimate relay send time, gateway send time and the offset.
    always_comb begin
        slots_back = TS_W'(slot_idx) - TS_W'(1);
        slot_span  = slots_back * slot_dur;
        relay_tx   = rx_time - link_delay;
        gw_tx      = relay_tx - slot_span;
        offset     = off_t'(bcn_ts - gw_tx);
    end
endmodule

// File: rtl/bo_capture.sv
// First-beacon capture for one sync sub-frame.
// Accepts a beacon only when none is held (or the sub-frame is starting
// in the same cycle), its slot is in 1..SCS_SLOTS and no end strobe is
// present. Keeps the stamp unmodified and the pending offset.
module bo_capture
    import beacon_pkg::*;
#(
    parameter int SCS_SLOTS = 16,
    parameter int SLOT_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scs_start,
    input  logic              scs_end,
    input  logic              bcn_valid,
    input  ts_t               bcn_ts,
    input  logic [SLOT_W-1:0] bcn_slot,
    input  off_t              calc_off,
    output logic              held,
    output ts_t               held_ts,
    output off_t              pend_off
);
    logic slot_ok;
    logic accept;

    // Decide whether this cycle's beacon counts as the sub-frame's first.
    always_comb begin
        slot_ok = (bcn_slot != '0) && (bcn_slot <= SLOT_W'(SCS_SLOTS));
        accept  = bcn_valid && slot_ok && !scs_end && (!held || scs_start);
    end

    // Hold flag, stored stamp and pending offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held     <= 1'b0;
            held_ts  <= '0;
            pend_off <= '0;
        end else begin
            if (scs_start) held <= 1'b0;
            if (accept) begin
                held     <= 1'b1;
                held_ts  <= bcn_ts;
                pend_off <= calc_off;
            end
        end
    end
endmodule

// File: rtl/bo_commit.sv
// End-of-sub-frame commit of the offset and clock correction.
// On the end strobe, copies the pending offset to the committed register
// when a beacon is held, and reports the sampled local time corrected by
// it (or unchanged if none is held). Assumes the strobe is one cycle.
module bo_commit
    import beacon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scs_end,
    input  logic held,
    input  off_t pend_off,
    input  ts_t  local_time,
    output off_t offset,
    output logic apply,
    output ts_t  corr_time
);
    // Commit register, apply pulse and corrected time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            offset    <= '0;
            apply     <= 1'b0;
            corr_time <= '0;
        end else begin
            apply <= scs_end;
            if (scs_end) begin
                if (held) begin
                    offset    <= pend_off;
                    corr_time <= local_time + ts_t'(pend_off);
                end else begin
                    corr_time <= local_time;
                end
            end
        end
    end
endmodule

// File: rtl/beacon_offset_est.sv
// Beacon clock offset estimator (top).
// Receives sync beacons during the sync sub-frame, keeps the first one,
// estimates the offset to the gateway clock and commits it at the common
// end of the sub-frame. Assumes start/end strobes are one cycle long and
// come from the slot scheduler.
module beacon_offset_est
    import beacon_pkg::*;
#(
    parameter int SCS_SLOTS = 16,
    localparam int SLOT_W   = $clog2(SCS_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scs_start_i,
    input  logic              scs_end_i,
    input  logic              bcn_valid_i,
    input  logic [31:0]       bcn_ts_i,
    input  logic [SLOT_W-1:0] bcn_slot_i,
    input  logic [31:0]       rx_time_i,
    input  logic [31:0]       link_delay_i,
    input  logic [31:0]       slot_dur_i,
    input  logic [31:0]       local_time_i,
    output logic              bcn_held_o,
    output logic [31:0]       held_ts_o,
    output logic [31:0]       offset_o,
    output logic              apply_o,
    output logic [31:0]       corr_time_o
);
    off_t calc_off;
    off_t pend_off;
    off_t off_q;

    bo_offset_calc #(.SLOT_W(SLOT_W)) u_calc (
        .bcn_ts     (bcn_ts_i),
        .slot_idx   (bcn_slot_i),
        .rx_time    (rx_time_i),
        .link_delay (link_delay_i),
        .slot_dur   (slot_dur_i),
        .offset     (calc_off)
    );

    bo_capture #(.SCS_SLOTS(SCS_SLOTS), .SLOT_W(SLOT_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .scs_start (scs_start_i),
        .scs_end   (scs_end_i),
        .bcn_valid (bcn_valid_i),
        .bcn_ts    (bcn_ts_i),
        .bcn_slot  (bcn_slot_i),
        .calc_off  (calc_off),
        .held      (bcn_held_o),
        .held_ts   (held_ts_o),
        .pend_off  (pend_off)
    );

    bo_commit u_commit (
        .clk        (clk),
        .rst_n      (rst_n),
        .scs_end    (scs_end_i),
        .held       (bcn_held_o),
        .pend_off   (pend_off),
        .local_time (local_time_i),
        .offset     (off_q),
        .apply      (apply_o),
        .corr_time  (corr_time_o)
    );

    assign offset_o = off_q;
endmodule

// File: rtl/beacon_offset_est_chk.sv
// Protocol checker for the beacon offset estimator, bound to the top.
module beacon_offset_est_chk #(
    parameter int SCS_SLOTS = 16,
    parameter int SLOT_W    = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scs_start_i,
    input logic              scs_end_i,
    input logic              bcn_valid_i,
    input logic [SLOT_W-1:0] bcn_slot_i,
    input logic [31:0]       local_time_i,
    input logic              bcn_held_o,
    input logic [31:0]       held_ts_o,
    input logic [31:0]       offset_o,
    input logic              apply_o,
    input logic [31:0]       corr_time_o
);
    // R3
    held_rise_needs_beacon_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bcn_held_o) |-> $past(bcn_valid_i));
    // R2
    held_stamp_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bcn_held_o && !scs_start_i) |=> $stable(held_ts_o));
    // R4
    offset_only_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !scs_end_i |=> $stable(offset_o));
    // R5
    apply_follows_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scs_end_i |=> apply_o);
    // R5
    apply_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !scs_end_i |=> !apply_o);
    // R6
    no_beacon_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scs_end_i && !bcn_held_o) |=> (corr_time_o == $past(local_time_i)));
    // R7
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scs_start_i && !bcn_valid_i) |=> !bcn_held_o);
    // R8
    bad_slot_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bcn_valid_i && !bcn_held_o && !scs_end_i &&
         ((bcn_slot_i == '0) || (bcn_slot_i > SLOT_W'(SCS_SLOTS)))) |=> !bcn_held_o);
    // R9
    end_beacon_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scs_end_i && !bcn_held_o) |=> !bcn_held_o);
endmodule

bind beacon_offset_est beacon_offset_est_chk #(
    .SCS_SLOTS(SCS_SLOTS), .SLOT_W(SLOT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .scs_start_i  (scs_start_i),
    .scs_end_i    (scs_end_i),
    .bcn_valid_i  (bcn_valid_i),
    .bcn_slot_i   (bcn_slot_i),
    .local_time_i (local_time_i),
    .bcn_held_o   (bcn_held_o),
    .held_ts_o    (held_ts_o),
    .offset_o     (offset_o),
    .apply_o      (apply_o),
    .corr_time_o  (corr_time_o)
);

// File: tb/tb_beacon_offset_est.sv
// Bench for the beacon offset estimator: behavioural reference model
// compared on every clock, plus directed checks with hand-worked values.
module tb_beacon_offset_est;
    localparam int P = 16;
    localparam int SW = $clog2(P + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scs_start = 0, scs_end = 0, bcn_valid = 0;
    logic [31:0] bcn_ts = 0, rx_time = 0, link_delay = 0, slot_dur = 0, local_time = 0;
    logic [SW-1:0] bcn_slot = 0;
    logic bcn_held, apply;
    logic [31:0] held_ts, offset, corr_time;

    int checks = 0;
    int fails = 0;
    bit model_on = 0;

    always #2 clk = ~clk;

    beacon_offset_est #(.SCS_SLOTS(P)) dut (
        .clk(clk), .rst_n(rst_n), .scs_start_i(scs_start), .scs_end_i(scs_end),
        .bcn_valid_i(bcn_valid), .bcn_ts_i(bcn_ts), .bcn_slot_i(bcn_slot),
        .rx_time_i(rx_time), .link_delay_i(link_delay), .slot_dur_i(slot_dur),
        .local_time_i(local_time), .bcn_held_o(bcn_held), .held_ts_o(held_ts),
        .offset_o(offset), .apply_o(apply), .corr_time_o(corr_time)
    );

    // Reference model state
    bit m_held = 0, m_apply = 0;
    logic [31:0] m_ts = 0, m_pend = 0, m_off = 0, m_corr = 0;

    // Behavioural model: follows the requirements, updated on each edge.
    always @(posedge clk) begin
        bit was_held;
        bit take;
        int unsigned slot;
        if (!rst_n) begin
            m_held = 0; m_apply = 0; m_ts = 0; m_pend = 0; m_off = 0; m_corr = 0;
        end else begin
            was_held = m_held;
            slot = bcn_slot;
            m_apply = scs_end;
            if (scs_end) begin
                if (was_held) begin
                    m_off = m_pend;
                    m_corr = local_time + m_pend;
                end else m_corr = local_time;
            end
            if (scs_start) m_held = 0;
            take = bcn_valid && !scs_end && slot >= 1 && slot <= P && (!was_held || scs_start);
            if (take) begin
                m_held = 1;
                m_ts = bcn_ts;
                m_pend = bcn_ts - ((rx_time - link_delay) - (slot - 1) * slot_dur);
            end
        end
    end

    // Per-cycle comparison against the model (R2 R3 R4 R5 R6).
    always @(negedge clk) begin
        if (model_on) begin
            checks++;
            if (bcn_held !== m_held || held_ts !== m_ts || offset !== m_off ||
                apply !== m_apply || corr_time !== m_corr) begin
                fails++;
                $display("FAIL model R2-model: held %0b/%0b ts %h/%h off %h/%h apply %0b/%0b corr %h/%h",
                         bcn_held, m_held, held_ts, m_ts, offset, m_off, apply, m_apply, corr_time, m_corr);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one beacon for one cycle; returns at the next falling edge.
    task automatic beacon(input logic [31:0] ts, input int sl, input logic [31:0] rx,
                          input logic [31:0] d, input logic [31:0] dur);
        bcn_valid = 1; bcn_ts = ts; bcn_slot = SW'(sl); rx_time = rx;
        link_delay = d; slot_dur = dur;
        @(negedge clk);
        bcn_valid = 0;
    endtask

    task automatic start_scs();
        scs_start = 1; @(negedge clk); scs_start = 0;
    endtask

    task automatic end_scs(input logic [31:0] lt);
        scs_end = 1; local_time = lt; @(negedge clk); scs_end = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        model_on = 1;
        // R11 reset state
        chk("R11 held", {31'b0, bcn_held}, 0);
        chk("R11 offset", offset, 0);
        chk("R11 apply", {31'b0, apply}, 0);
        chk("R11 corr", corr_time, 0);

        // R1 slot 1: send 1050-20=1030, offset -30
        start_scs();
        beacon(1000, 1, 1050, 20, 100);
        chk("R3 held", {31'b0, bcn_held}, 1);
        chk("R3 stamp", held_ts, 1000);
        chk("R4 not yet", offset, 0);
        end_scs(2000);
        chk("R5 apply", {31'b0, apply}, 1);
        chk("R1 offset slot1", offset, 32'hFFFF_FFE2);
        chk("R5 corr", corr_time, 1970);
        @(negedge clk);
        chk("R5 pulse ends", {31'b0, apply}, 0);

        // R1 slot 3 then R2 second beacon discarded: 5590-200=5390, -390
        start_scs();
        chk("R7 cleared", {31'b0, bcn_held}, 0);
        beacon(5000, 3, 5600, 10, 100);
        beacon(9000, 5, 9100, 10, 100);
        chk("R2 stamp kept", held_ts, 5000);
        end_scs(100);
        chk("R2 offset first", offset, 32'hFFFF_FE7A);

        // R6 no beacon
        start_scs();
        end_scs(32'h1234);
        chk("R6 corr", corr_time, 32'h1234);
        chk("R6 offset kept", offset, 32'hFFFF_FE7A);

        // R10 wrap: gw send FFFFFFE0, offset +0x30
        start_scs();
        beacon(32'h10, 1, 32'hFFFF_FFF0, 32'h10, 7);
        end_scs(32'hFFFF_FFFF);
        chk("R10 offset", offset, 32'h30);
        chk("R10 corr", corr_time, 32'h2F);

        // R8 slot 0 and P+1 discarded, slot P accepted: 1000-5-15*50=245
        start_scs();
        beacon(77, 0, 500, 0, 1);
        chk("R8 slot0", {31'b0, bcn_held}, 0);
        beacon(78, P + 1, 500, 0, 1);
        chk("R8 slotP+1", {31'b0, bcn_held}, 0);
        beacon(500, P, 1000, 5, 50);
        chk("R8 slotP held", held_ts, 500);
        end_scs(0);
        chk("R8 slotP offset", offset, 32'd255);

        // R9 beacon with end strobe discarded
        start_scs();
        bcn_valid = 1; bcn_ts = 42; bcn_slot = 1; rx_time = 0; link_delay = 0;
        end_scs(10);
        bcn_valid = 0;
        chk("R9 held", {31'b0, bcn_held}, 0);
        chk("R9 offset", offset, 32'd255);

        // R7 beacon in start cycle replaces the held one
        start_scs();
        beacon(11, 1, 11, 0, 0);
        scs_start = 1;
        beacon(2000, 2, 1900, 0, 100);
        scs_start = 0;
        chk("R7 new stamp", held_ts, 2000);
        end_scs(0);
        chk("R7 offset", offset, 32'd200);

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule